// File: doc/BRIEF.md
# Six-Channel Compare-Match Timer Bank

This block holds six independent up-counters behind a word-addressed register bus. Software programs each channel with a compare value, an operating mode (single shot, periodic reload or free-running), a tick source (fast system tick or slow real-time tick) and an optional divide-by-two. The block then counts tick pulses on its own. A channel that reaches its compare value raises a pending flag. One interrupt line reports every pending flag whose enable bit is set.

A typical use dedicates one channel to free-running timekeeping and a second channel to periodic or next-event interrupts. The shared register at the base of the map enables interrupts, and the one next to it acknowledges them. The tick inputs are single-cycle enable pulses made outside the block. All logic runs on one clock.

Top module: `gpt_bank`

## Requirements
- R1: After a synchronous active-low reset, every readable register returns 0 and `irq_out` is low.
- R2: Channel n (1 to 6) decodes control at byte address 16n, tick setup at 16n+4, live counter at 16n+8 and compare at 16n+12. Interrupt enable is at 0x00, and the pending/acknowledge register is at 0x08, with channel n on bit n-1. Control reads back bit 0 (run) and bits [5:4] (mode). Tick setup reads back bit 4 (source) and bit 0 (divide). Compare reads back its stored value. Any other address reads 0.
- R3: A running channel (control bit 0 = 1) advances by one on each pulse of the tick chosen by tick-setup bit 4: 0 selects `fast_tick` and 1 selects `slow_tick`. Pulses of the other tick are ignored. A stopped channel holds its count.
- R4: With tick-setup bit 0 = 1, the counter advances only on every second selected pulse. The first advance follows the second pulse after a clear.
- R5: Control bit 1 is a self-clearing restart. A control write with it set forces the counter to 0 on that cycle, which overrides any advance, and loads the new run bit and mode. The bit always reads back 0.
- R6: Mode 0 (single shot) applies when an advance finds the counter equal to compare. The channel then sets its pending bit, clears its run bit and keeps the counter at the compare value.
- R7: Mode 1 (periodic) applies when an advance finds the counter equal to compare. The counter then returns to 0 and pending is set. The period is compare+1 advances, and pending is set on every match.
- R8: Mode 3 (free-running) counts past the compare value and wraps from all-ones to 0. It never sets a pending bit.
- R9: Writing to 0x08 clears each pending bit whose data bit is 1. Bits written as 0 are unchanged.
- R10: `irq_out` is high exactly when some pending bit has its enable bit (0x00, same bit position) set.
- R11: When a match and an acknowledge of the same pending bit fall in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_tick | input | 1 | Fast system tick pulse |
| slow_tick | input | 1 | Slow real-time tick pulse |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of `bus_rd` |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A compare match and a software acknowledge can both try to change the same pending flag at one clock edge. The bench sets up this collision on a periodic channel whose compare value is small. It counts idle cycles from the restart write so that the acknowledge write lands on the edge where the match occurs. The flag must read back as still set. An acknowledge one cycle off the match must clear it, which shows that the collision was really hit and not missed.

// File: rtl/gpt_pkg.sv
// Shared constants and types for the timer bank.
// Assumes a byte-addressed bus with one 32-bit word per register slot.
package gpt_pkg;

    typedef enum logic [1:0] {
        MODE_ONCE = 2'd0,
        MODE_LOOP = 2'd1,
        MODE_RSVD = 2'd2,
        MODE_FREE = 2'd3
    } run_mode_e;

    // register slot inside a 16-byte channel window (address bits [3:2])
    localparam logic [1:0] SLOT_CTRL = 2'd0;
    localparam logic [1:0] SLOT_TICK = 2'd1;
    localparam logic [1:0] SLOT_CNT  = 2'd2;
    localparam logic [1:0] SLOT_CMP  = 2'd3;

    // control and tick-setup bit positions
    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_CLR_BIT  = 1;
    localparam int CTRL_MODE_LSB = 4;
    localparam int TICK_SRC_BIT  = 4;
    localparam int TICK_DIV_BIT  = 0;

endpackage

// File: rtl/gpt_chan.sv
// One timer channel: configuration, tick selection, divider, counter and
// compare. Emits a one-cycle hit pulse on a match in single-shot or periodic mode.
// Assumes tick inputs are single-cycle pulses synchronous to clk.
module gpt_chan
    import gpt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fast_tick,
    input  logic             slow_tick,
    input  logic             ctrl_we,
    input  logic             tick_we,
    input  logic             cmp_we,
    input  logic             wr_run,
    input  logic             wr_clr,
    input  logic [1:0]       wr_mode,
    input  logic             wr_src,
    input  logic             wr_div,
    input  logic [CNT_W-1:0] wr_cmp,
    output logic             run_o,
    output logic [1:0]       mode_o,
    output logic             src_o,
    output logic             div_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic             hit_o
);

    logic             run_q, src_q, div_q, phase_q;
    run_mode_e        mode_q;
    logic [CNT_W-1:0] cnt_q, cmp_q;
    logic             tick_sel, step, restart, hit;

    // selected tick, divided advance, and match detection
    always_comb begin
        tick_sel = src_q ? slow_tick : fast_tick;
        step     = run_q && tick_sel && (!div_q || phase_q);
        restart  = ctrl_we && wr_clr;
        hit      = step && (cnt_q == cmp_q) &&
                   ((mode_q == MODE_ONCE) || (mode_q == MODE_LOOP));
    end

    // run bit and mode: loaded by control writes, run dropped after a single shot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            mode_q <= MODE_ONCE;
        end else if (ctrl_we) begin
            run_q  <= wr_run;
            mode_q <= run_mode_e'(wr_mode);
        end else if (hit && (mode_q == MODE_ONCE)) begin
            run_q  <= 1'b0;
        end
    end

    // tick source and divider selection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= 1'b0;
            div_q <= 1'b0;
        end else if (tick_we) begin
            src_q <= wr_src;
            div_q <= wr_div;
        end
    end

    // compare value storage
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '0;
        else if (cmp_we) cmp_q <= wr_cmp;
    end

    // divide-by-two phase, realigned by a restart
    always_ff @(posedge clk) begin
        if (!rst_n)                            phase_q <= 1'b0;
        else if (restart)                      phase_q <= 1'b0;
        else if (run_q && tick_sel && div_q)   phase_q <= ~phase_q;
    end

    // counter: restart wins, then match handling, then plain advance
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (restart)               cnt_q <= '0;
        else if (hit) begin
            if (mode_q == MODE_LOOP)    cnt_q <= '0;
        end else if (step)              cnt_q <= cnt_q + 1'b1;
    end

    assign run_o  = run_q;
    assign mode_o = mode_q;
    assign src_o  = src_q;
    assign div_o  = div_q;
    assign cnt_o  = cnt_q;
    assign cmp_o  = cmp_q;
    assign hit_o  = hit;

endmodule

// File: rtl/gpt_irq.sv
// Shared interrupt state: enable mask, pending flags with write-one-to-clear
// acknowledge, and the combined request. Assumes hit inputs are one-cycle pulses.
module gpt_irq #(
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_we,
    input  logic           ack_we,
    input  logic [NCH-1:0] wr_bits,
    input  logic [NCH-1:0] hit,
    output logic [NCH-1:0] en_o,
    output logic [NCH-1:0] pend_o,
    output logic           irq_o
);

    logic [NCH-1:0] en_q, pend_q, ack_mask;

    // acknowledge mask is only live during a write to the acknowledge slot
    always_comb ack_mask = ack_we ? wr_bits : '0;

    // enable mask register
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_we) en_q <= wr_bits;
    end

    // pending flags: a new hit outranks an acknowledge in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~ack_mask) | hit;
    end

    assign en_o   = en_q;
    assign pend_o = pend_q;
    assign irq_o  = |(pend_q & en_q);

endmodule

// File: rtl/gpt_regdec.sv
// Address decode: per-channel write strobes, shared-register strobes and the
// read-data multiplexer. Assumes word-aligned addresses (bits [1:0] zero).
module gpt_regdec
    import gpt_pkg::*;
#(
    parameter int NCH    = 6,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          wr,
    input  logic                          rd,
    input  logic [NCH-1:0][DATA_W-1:0]    ctrl_rd,
    input  logic [NCH-1:0][DATA_W-1:0]    tick_rd,
    input  logic [NCH-1:0][DATA_W-1:0]    cnt_rd,
    input  logic [NCH-1:0][DATA_W-1:0]    cmp_rd,
    input  logic [DATA_W-1:0]             en_rd,
    input  logic [DATA_W-1:0]             pend_rd,
    output logic [NCH-1:0]                ctrl_we,
    output logic [NCH-1:0]                tick_we,
    output logic [NCH-1:0]                cmp_we,
    output logic                          en_we,
    output logic                          ack_we,
    output logic [DATA_W-1:0]             rdata
);

    localparam int WIN_W = ADDR_W - 4;

    logic [WIN_W-1:0] win;
    logic [1:0]       slot;
    logic             aligned;

    // split the address into channel window and register slot
    always_comb begin
        win     = addr[ADDR_W-1:4];
        slot    = addr[3:2];
        aligned = (addr[1:0] == 2'b00);
        en_we   = wr && aligned && (win == '0) && (slot == SLOT_CTRL);
        ack_we  = wr && aligned && (win == '0) && (slot == SLOT_CNT);
    end

    // per-channel write strobes
    for (genvar i = 0; i < NCH; i++) begin : g_we
        logic sel;
        assign sel        = wr && aligned && (win == WIN_W'(i + 1));
        assign ctrl_we[i] = sel && (slot == SLOT_CTRL);
        assign tick_we[i] = sel && (slot == SLOT_TICK);
        assign cmp_we[i]  = sel && (slot == SLOT_CMP);
    end

    // read multiplexer; unmapped addresses and idle cycles return zero
    always_comb begin
        rdata = '0;
        if (rd && aligned) begin
            if (win == '0) begin
                if (slot == SLOT_CTRL)     rdata = en_rd;
                else if (slot == SLOT_CNT) rdata = pend_rd;
            end
            for (int i = 0; i < NCH; i++) begin
                if (win == WIN_W'(i + 1)) begin
                    case (slot)
                        SLOT_CTRL: rdata = ctrl_rd[i];
                        SLOT_TICK: rdata = tick_rd[i];
                        SLOT_CNT:  rdata = cnt_rd[i];
                        default:   rdata = cmp_rd[i];
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/gpt_bank.sv
// Top of the timer bank: NCH channels, the shared interrupt block and the
// register decode. Assumes CNT_W <= DATA_W, NCH <= DATA_W and NCH < 2**(ADDR_W-4).
module gpt_bank
    import gpt_pkg::*;
#(
    parameter int NCH    = 6,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_tick,
    input  logic              slow_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);

    logic [NCH-1:0]              ctrl_we, tick_we, cmp_we;
    logic                        en_we, ack_we;
    logic [NCH-1:0]              ch_run, ch_src, ch_div, ch_hit;
    logic [NCH-1:0][1:0]         ch_mode;
    logic [NCH-1:0][CNT_W-1:0]   ch_cnt, ch_cmp;
    logic [NCH-1:0][DATA_W-1:0]  ctrl_rd, tick_rd, cnt_rd, cmp_rd;
    logic [NCH-1:0]              irq_en, pend;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        gpt_chan #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .fast_tick (fast_tick),
            .slow_tick (slow_tick),
            .ctrl_we   (ctrl_we[i]),
            .tick_we   (tick_we[i]),
            .cmp_we    (cmp_we[i]),
            .wr_run    (bus_wdata[CTRL_RUN_BIT]),
            .wr_clr    (bus_wdata[CTRL_CLR_BIT]),
            .wr_mode   (bus_wdata[CTRL_MODE_LSB +: 2]),
            .wr_src    (bus_wdata[TICK_SRC_BIT]),
            .wr_div    (bus_wdata[TICK_DIV_BIT]),
            .wr_cmp    (bus_wdata[CNT_W-1:0]),
            .run_o     (ch_run[i]),
            .mode_o    (ch_mode[i]),
            .src_o     (ch_src[i]),
            .div_o     (ch_div[i]),
            .cnt_o     (ch_cnt[i]),
            .cmp_o     (ch_cmp[i]),
            .hit_o     (ch_hit[i])
        );

        // readback words for this channel
        always_comb begin
            ctrl_rd[i]                      = '0;
            ctrl_rd[i][CTRL_RUN_BIT]        = ch_run[i];
            ctrl_rd[i][CTRL_MODE_LSB +: 2]  = ch_mode[i];
            tick_rd[i]                      = '0;
            tick_rd[i][TICK_SRC_BIT]        = ch_src[i];
            tick_rd[i][TICK_DIV_BIT]        = ch_div[i];
            cnt_rd[i]                       = DATA_W'(ch_cnt[i]);
            cmp_rd[i]                       = DATA_W'(ch_cmp[i]);
        end
    end

    gpt_irq #(.NCH(NCH)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_we   (en_we),
        .ack_we  (ack_we),
        .wr_bits (bus_wdata[NCH-1:0]),
        .hit     (ch_hit),
        .en_o    (irq_en),
        .pend_o  (pend),
        .irq_o   (irq_out)
    );

    gpt_regdec #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .addr    (bus_addr),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .ctrl_rd (ctrl_rd),
        .tick_rd (tick_rd),
        .cnt_rd  (cnt_rd),
        .cmp_rd  (cmp_rd),
        .en_rd   (DATA_W'(irq_en)),
        .pend_rd (DATA_W'(pend)),
        .ctrl_we (ctrl_we),
        .tick_we (tick_we),
        .cmp_we  (cmp_we),
        .en_we   (en_we),
        .ack_we  (ack_we),
        .rdata   (bus_rdata)
    );

endmodule

// File: rtl/gpt_bank_chk.sv
// Property checker for gpt_bank, attached by bind. Observes bus traffic,
// per-channel hit pulses, pending flags and counters.
module gpt_bank_chk #(
    parameter int NCH    = 6,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic                      bus_wr,
    input logic [DATA_W-1:0]         bus_wdata,
    input logic                      irq_out,
    input logic [NCH-1:0]            ch_hit,
    input logic [NCH-1:0]            ch_run,
    input logic [NCH-1:0][1:0]       ch_mode,
    input logic [NCH-1:0][CNT_W-1:0] ch_cnt,
    input logic [NCH-1:0]            pend,
    input logic [NCH-1:0]            irq_en
);

    localparam logic [ADDR_W-1:0] ACK_ADDR = ADDR_W'(8);

    // interrupt request never rises without some enable bit (R10)
    a_r10_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (irq_en != '0));

    for (genvar i = 0; i < NCH; i++) begin : g_p
        logic ctrl_wr, ack_one, ack_zero;
        assign ctrl_wr  = bus_wr && (bus_addr == ADDR_W'((i + 1) * 16));
        assign ack_one  = bus_wr && (bus_addr == ACK_ADDR) && bus_wdata[i];
        assign ack_zero = bus_wr && (bus_addr == ACK_ADDR) && !bus_wdata[i];

        // a match always leaves the flag set, acknowledge or not (R11)
        a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            ch_hit[i] |=> pend[i]);

        // acknowledge with a 1 clears the flag when no match coincides (R9)
        a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_one && !ch_hit[i]) |=> !pend[i]);

        // acknowledge with a 0 keeps the flag (R9)
        a_r9_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_zero && pend[i]) |=> pend[i]);

        // single shot drops the run bit after its match (R6)
        a_r6_disarm: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_hit[i] && (ch_mode[i] == 2'd0) && !ctrl_wr) |=> !ch_run[i]);

        // restart bit zeroes the counter on the next cycle (R5)
        a_r5_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_wr && bus_wdata[1]) |=> (ch_cnt[i] == '0));

        // free-running channels never match (R8)
        a_r8_free_silent: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_mode[i] == 2'd3) |-> !ch_hit[i]);
    end

endmodule

bind gpt_bank gpt_bank_chk #(
    .NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_gpt_bank_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .irq_out   (irq_out),
    .ch_hit    (ch_hit),
    .ch_run    (ch_run),
    .ch_mode   (ch_mode),
    .ch_cnt    (ch_cnt),
    .pend      (pend),
    .irq_en    (irq_en)
);

// File: tb/test_gpt_bank.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected values, a monitor compares
// them against bus reads or the interrupt line half a cycle after each edge.
module test_gpt_bank;

    localparam int NCH    = 6;
    localparam int CNT_W  = 12;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fast_tick = 1'b0;
    logic              slow_tick = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq_out;
    logic              peek = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    gpt_bank #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_gpt_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .fast_tick (fast_tick),
        .slow_tick (slow_tick),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    always #2.5 clk = ~clk;

    function automatic logic [7:0] a_ctrl(int n); return 8'(16 * n);      endfunction
    function automatic logic [7:0] a_tick(int n); return 8'(16 * n + 4);  endfunction
    function automatic logic [7:0] a_cnt(int n);  return 8'(16 * n + 8);  endfunction
    function automatic logic [7:0] a_cmp(int n);  return 8'(16 * n + 12); endfunction

    // driver: one write, lands on the next rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // driver: one read, expected value queued for the monitor
    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        item_t it;
        it.is_irq = 1'b0; it.exp = e; it.tag = t;
        sb.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // driver: interrupt line check
    task automatic chk_irq(input bit e, input string t);
        item_t it;
        it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = t;
        sb.push_back(it);
        peek = 1'b1;
        @(negedge clk);
        peek = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops one expected item for each observed read or peek
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (bus_rd || peek) begin
                logic [31:0] act;
                n_run++;
                if (sb.size() == 0) begin
                    n_fail++;
                    $display("FAIL scoreboard: observation with empty queue, actual %h expected none", bus_rdata);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    act = it.is_irq ? {31'b0, irq_out} : bus_rdata;
                    if (act !== it.exp) begin
                        n_fail++;
                        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(a_ctrl(1), 32'h0, "R1 ctrl ch1");
        rd(a_tick(1), 32'h0, "R1 tick ch1");
        rd(a_cmp(6),  32'h0, "R1 cmp ch6");
        rd(a_cnt(6),  32'h0, "R1 cnt ch6");
        rd(8'h00,     32'h0, "R1 enable");
        rd(8'h08,     32'h0, "R1 pending");
        chk_irq(1'b0, "R1 irq low");

        // R2: register map and readback
        wr(a_tick(6), 32'h11);
        rd(a_tick(6), 32'h11, "R2 tick readback");
        wr(a_cmp(6), 32'h5A5);
        rd(a_cmp(6), 32'h5A5, "R2 cmp readback");
        wr(a_ctrl(6), 32'h33);
        rd(a_ctrl(6), 32'h31, "R2 ctrl readback, R5 clear reads 0");
        wr(a_ctrl(6), 32'h0);
        rd(8'h04, 32'h0, "R2 unmapped");

        // R3: no tick, no advance
        wr(a_ctrl(1), 32'h33);
        idle(3);
        rd(a_cnt(1), 32'h0, "R3 no tick");

        // R3/R5: fast tick each cycle, restart then count
        fast_tick = 1'b1;
        wr(a_ctrl(1), 32'h33);
        rd(a_cnt(1), 32'd0, "R5 restart to zero");
        rd(a_cnt(1), 32'd1, "R3 count 1");
        rd(a_cnt(1), 32'd2, "R3 count 2");
        wr(a_ctrl(1), 32'h30);
        rd(a_cnt(1), 32'd4, "R3 stop edge");
        idle(2);
        rd(a_cnt(1), 32'd4, "R3 stopped holds");
        wr(a_ctrl(1), 32'h02);
        rd(a_cnt(1), 32'd0, "R5 clear while stopped");

        // R3: slow source ignores fast pulses
        wr(a_tick(1), 32'h10);
        wr(a_ctrl(1), 32'h33);
        idle(3);
        rd(a_cnt(1), 32'd0, "R3 slow src ignores fast");
        slow_tick = 1'b1;
        @(negedge clk);
        slow_tick = 1'b0;
        rd(a_cnt(1), 32'd1, "R3 slow tick advances");
        wr(a_ctrl(1), 32'h0);

        // R4: divide by two on the fast tick
        wr(a_tick(1), 32'h01);
        wr(a_ctrl(1), 32'h33);
        rd(a_cnt(1), 32'd0, "R4 div2 t0");
        rd(a_cnt(1), 32'd0, "R4 div2 t1");
        rd(a_cnt(1), 32'd1, "R4 div2 t2");
        rd(a_cnt(1), 32'd1, "R4 div2 t3");
        rd(a_cnt(1), 32'd2, "R4 div2 t4");
        wr(a_ctrl(1), 32'h0);

        // R6: single shot on channel 2, compare 3
        wr(a_cmp(2), 32'd3);
        wr(a_ctrl(2), 32'h03);
        idle(8);
        rd(a_cnt(2), 32'd3, "R6 count holds at compare");
        rd(a_ctrl(2), 32'h0, "R6 run bit cleared");
        rd(8'h08, 32'h02, "R6 pending bit 1");
        chk_irq(1'b0, "R10 masked");
        wr(8'h00, 32'h02);
        chk_irq(1'b1, "R10 enabled pending");
        wr(8'h08, 32'h01);
        rd(8'h08, 32'h02, "R9 other bit untouched");
        wr(8'h08, 32'h00);
        rd(8'h08, 32'h02, "R9 zero write no effect");
        wr(8'h08, 32'h3F);
        rd(8'h08, 32'h0, "R9 clear all");
        chk_irq(1'b0, "R10 cleared");

        // R7: periodic on channel 3, compare 2, period 3
        wr(a_cmp(3), 32'd2);
        wr(a_ctrl(3), 32'h13);
        rd(a_cnt(3), 32'd0, "R7 seq 0");
        rd(a_cnt(3), 32'd1, "R7 seq 1");
        rd(a_cnt(3), 32'd2, "R7 seq 2");
        rd(a_cnt(3), 32'd0, "R7 reload");
        rd(a_cnt(3), 32'd1, "R7 seq 1b");
        rd(a_cnt(3), 32'd2, "R7 seq 2b");
        rd(a_cnt(3), 32'd0, "R7 reload b");
        rd(8'h08, 32'h04, "R7 pending bit 2");
        wr(a_ctrl(3), 32'h10);
        wr(8'h08, 32'h3F);
        rd(8'h08, 32'h0, "R9 ack clears");

        // R11: acknowledge landing on the match edge
        wr(a_ctrl(3), 32'h13);
        idle(2);
        wr(8'h08, 32'h04);
        rd(8'h08, 32'h04, "R11 set wins over ack");
        wr(8'h08, 32'h04);
        rd(8'h08, 32'h0, "R11 ack off the match clears");
        wr(a_ctrl(3), 32'h10);
        wr(8'h08, 32'h3F);

        // R8: free-run wraps and ignores compare
        wr(a_cmp(4), 32'd5);
        wr(a_ctrl(4), 32'h33);
        idle(4095);
        rd(a_cnt(4), 32'hFFF, "R8 all ones");
        rd(a_cnt(4), 32'h0, "R8 wrap to zero");
        rd(8'h08, 32'h0, "R8 no pending");
        wr(a_ctrl(4), 32'h0);

        // R10: combined request follows pending and enable
        wr(8'h00, 32'h3F);
        chk_irq(1'b0, "R10 nothing pending");
        wr(a_cmp(5), 32'd1);
        wr(a_ctrl(5), 32'h13);
        idle(3);
        chk_irq(1'b1, "R10 periodic ch5 pending");
        wr(8'h00, 32'h0);
        chk_irq(1'b0, "R10 enable gates");
        wr(a_ctrl(5), 32'h0);

        idle(2);
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
        end
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule